// File: doc/BRIEF.md
# Subroutine Frame Link/Unlink Sequencer

This block carries out the stack-frame work of a processor's subroutine call and return. It works as a multi-cycle engine beside the register file. Register 0 serves as the frame pointer and register 1 as the stack pointer. The core pulses a start strobe and presents five values together with it:

- the kind of operation,
- the PC of the call or return instruction,
- the call destination,
- the current frame pointer,
- the current stack pointer.

The sequencer then issues word accesses to a single-port data memory, one at a time. When it finishes, it hands back the new frame pointer, stack pointer and PC.

Each call frame holds three words:

- the saved frame pointer at the lowest address,
- the return address above it,
- an unused static-chain word at the top.

A call builds the frame downward from the stack pointer and leaves both pointers on the saved frame pointer. A return unwinds the frame from the frame pointer upward, skipping the static-chain word. Instruction decode stays outside the block. The call destination is either an immediate taken from the instruction or a register value, and the core resolves it before start.

Top module: `callret_frame_seq`

## Requirements
- R1: While reset is held and right after it is released, `done`, `busy` and `mem_req` are 0 and `fp_o`, `sp_o` and `pc_o` are all zero.
- R2: For an absolute call (`op` = 2'b00), the first memory access is a write of `pc_i + 6` to address `sp_i - 8`.
- R3: For a register-indirect call (`op` = 2'b01), the first memory access is a write of `pc_i + 2` to address `sp_i - 8`. After completion, `pc_o` equals `target_i` as presented at start.
- R4: The second access of either call writes `fp_i` to address `sp_i - 12`. At completion, `fp_o` and `sp_o` both equal `sp_i - 12` and `pc_o` equals `target_i`.
- R5: For a return (`op` = 2'b10), the first access reads the word at `fp_i` and the second reads the word at `fp_i + 4`. At completion, `fp_o` is the first word read, `pc_o` is the second, and `sp_o` is `fp_i + 12`.
- R6: Exactly one access is outstanding at a time. `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_rvalid`, and every operation performs exactly two accesses whatever the response latency.
- R7: `done` is high for exactly one cycle, in the cycle after the response to the second access. `busy` is high from the cycle after an accepted start until that cycle, and is low while `done` is high.
- R8: A start strobe that arrives while `busy` is high has no effect. The running operation completes with its original results and only one `done`.
- R9: The operation code 2'b11 is reserved. A start carrying it raises no `busy`, no `mem_req` and no `done`, and leaves `fp_o`, `sp_o` and `pc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 00 absolute call, 01 register call, 10 return, 11 reserved |
| pc_i | input | 32 | Address of the call or return instruction |
| target_i | input | 32 | Resolved call destination |
| fp_i | input | 32 | Current frame pointer (register 0) |
| sp_i | input | 32 | Current stack pointer (register 1) |
| mem_req | output | 1 | Memory access request, held until response |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word access address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |
| fp_o | output | 32 | Resulting frame pointer |
| sp_o | output | 32 | Resulting stack pointer |
| pc_o | output | 32 | Resulting PC |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The internal step register decides which address and data go out. A wrong step or pointer update therefore shows up as soon as the next access is requested: the bench logs every address, direction and write word, one response latency later. A missed transition shows up within the bench's wait window as a missing or extra `done` or a wrong access count. Errors in the final pointers are seen on the cycle `done` rises. A call followed by a return, with the call's results fed back, checks that the two walk the same frame layout.

// File: rtl/crs_pkg.sv
package crs_pkg;
    localparam int WORD_W     = 32;
    localparam int OP_W       = 2;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LINK_BYTES = 2 * WORD_BYTES;   // return address + static-chain word
    localparam int LEN_ABS    = 6;                // opcode + 32-bit immediate
    localparam int LEN_REG    = 2;                // opcode only

    localparam logic [OP_W-1:0] OP_CALL_ABS = 2'd0;
    localparam logic [OP_W-1:0] OP_CALL_REG = 2'd1;
    localparam logic [OP_W-1:0] OP_RETURN   = 2'd2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUT_RA,   // write return address
        ST_PUT_FP,   // write caller frame pointer
        ST_GET_FP,   // read caller frame pointer
        ST_GET_PC    // read return address
    } step_e;

    typedef struct packed {
        logic  req;
        logic  we;
        word_t addr;
        word_t wdata;
    } mem_cmd_t;

    function automatic word_t link_addr(word_t pc, logic is_abs);
        return pc + word_t'(is_abs ? LEN_ABS : LEN_REG);
    endfunction

    function automatic logic op_known(logic [OP_W-1:0] code);
        return code == OP_CALL_ABS || code == OP_CALL_REG || code == OP_RETURN;
    endfunction
endpackage

// File: rtl/crs_ctrl.sv
module crs_ctrl
    import crs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] op,
    input  logic            mem_rvalid,
    output step_e           state,
    output logic            accept,
    output logic            advance,
    output logic            done
);
    step_e state_d;

    assign accept  = (state == ST_IDLE) && start && op_known(op);
    assign advance = (state != ST_IDLE) && mem_rvalid;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (accept)  state_d = (op == OP_RETURN) ? ST_GET_FP : ST_PUT_RA;
            ST_PUT_RA: if (advance) state_d = ST_PUT_FP;
            ST_PUT_FP: if (advance) state_d = ST_IDLE;
            ST_GET_FP: if (advance) state_d = ST_GET_PC;
            ST_GET_PC: if (advance) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_d;
            done  <= advance && (state == ST_PUT_FP || state == ST_GET_PC);
        end
    end
endmodule

// File: rtl/crs_frame.sv
module crs_frame
    import crs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  step_e           state,
    input  logic            accept,
    input  logic            advance,
    input  logic [OP_W-1:0] op,
    input  word_t           pc_i,
    input  word_t           target_i,
    input  word_t           fp_i,
    input  word_t           sp_i,
    input  word_t           rdata,
    output word_t           fp_q,
    output word_t           sp_q,
    output word_t           pc_q,
    output mem_cmd_t        cmd
);
    localparam word_t STEP_WORD = word_t'(WORD_BYTES);
    localparam word_t STEP_LINK = word_t'(LINK_BYTES);

    word_t link_q;
    word_t tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fp_q   <= '0;
            sp_q   <= '0;
            pc_q   <= '0;
            link_q <= '0;
            tgt_q  <= '0;
        end else if (accept) begin
            fp_q <= fp_i;
            if (op == OP_RETURN) begin
                sp_q <= fp_i;                       // unwind starts at the frame
            end else begin
                sp_q   <= sp_i - STEP_LINK;         // reserve link + static-chain slot
                link_q <= link_addr(pc_i, op == OP_CALL_ABS);
                tgt_q  <= target_i;
            end
        end else if (advance) begin
            unique case (state)
                ST_PUT_RA: sp_q <= sp_q - STEP_WORD;
                ST_PUT_FP: begin
                    fp_q <= sp_q;
                    pc_q <= tgt_q;
                end
                ST_GET_FP: begin
                    fp_q <= rdata;
                    sp_q <= sp_q + STEP_WORD;
                end
                ST_GET_PC: begin
                    pc_q <= rdata;
                    sp_q <= sp_q + STEP_LINK;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd.req   = (state != ST_IDLE);
        cmd.we    = (state == ST_PUT_RA) || (state == ST_PUT_FP);
        cmd.addr  = sp_q;
        cmd.wdata = (state == ST_PUT_RA) ? link_q :
                    (state == ST_PUT_FP) ? fp_q   : '0;
    end
endmodule

// File: rtl/callret_frame_seq.sv
module callret_frame_seq
    import crs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] target_i,
    input  logic [WORD_W-1:0] fp_i,
    input  logic [WORD_W-1:0] sp_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] fp_o,
    output logic [WORD_W-1:0] sp_o,
    output logic [WORD_W-1:0] pc_o,
    output logic              busy,
    output logic              done
);
    step_e    state;
    logic     accept;
    logic     advance;
    mem_cmd_t cmd;

    crs_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op         (op),
        .mem_rvalid (mem_rvalid),
        .state      (state),
        .accept     (accept),
        .advance    (advance),
        .done       (done)
    );

    crs_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .accept   (accept),
        .advance  (advance),
        .op       (op),
        .pc_i     (pc_i),
        .target_i (target_i),
        .fp_i     (fp_i),
        .sp_i     (sp_i),
        .rdata    (mem_rdata),
        .fp_q     (fp_o),
        .sp_q     (sp_o),
        .pc_q     (pc_o),
        .cmd      (cmd)
    );

    assign busy      = (state != ST_IDLE);
    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;
endmodule

// File: rtl/callret_frame_seq_chk.sv
module callret_frame_seq_chk
    import crs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OP_W-1:0]   op,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_rvalid,
    input logic              busy,
    input logic              done
);
    // R6: a pending access is held unchanged until its response
    p_hold_req_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: completion pulse lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: sequencer is idle when it reports completion
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req));

    // R7: an accepted start makes the block busy and requesting
    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && op != 2'b11) |=> (busy && mem_req));

    // R8: a start while busy never yields a completion on the next cycle unless a response came
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !mem_rvalid) |=> (busy && !done));

    // R9: reserved code starts nothing
    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && op == 2'b11) |=> (!busy && !mem_req && !done));
endmodule

bind callret_frame_seq callret_frame_seq_chk u_chk (.*);

// File: tb/callret_frame_seq_test.sv
`timescale 1ns/1ps
module callret_frame_seq_test;
    localparam time CYC = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] pc_i = '0, target_i = '0, fp_i = '0, sp_i = '0;
    logic        mem_req, mem_we, mem_rvalid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] fp_o, sp_o, pc_o;
    logic        busy, done;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int wcnt   = 0;
    int acc_n  = 0;
    int done_n = 0;
    logic [31:0] mem [0:63];
    logic [31:0] log_addr [0:3];
    logic [31:0] log_wdata [0:3];
    logic        log_we [0:3];

    always #(CYC/2) clk = ~clk;

    callret_frame_seq uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .pc_i(pc_i), .target_i(target_i), .fp_i(fp_i), .sp_i(sp_i),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fp_o(fp_o), .sp_o(sp_o), .pc_o(pc_o), .busy(busy), .done(done)
    );

    // memory model with programmable response latency
    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            wcnt       <= 0;
        end else if (mem_req && !mem_rvalid) begin
            if (wcnt >= lat) begin
                mem_rvalid <= 1'b1;
                wcnt       <= 0;
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:2]];
                if (acc_n < 4) begin
                    log_addr[acc_n]  <= mem_addr;
                    log_we[acc_n]    <= mem_we;
                    log_wdata[acc_n] <= mem_wdata;
                end
                acc_n <= acc_n + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_rvalid <= 1'b0;
        end
        if (done) done_n <= done_n + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // launch one operation and wait for done; checks busy and pulse width (R7)
    task automatic run_op(input logic [1:0] code, input logic [31:0] pc, input logic [31:0] tgt,
                          input logic [31:0] fp, input logic [31:0] sp);
        int n;
        @(negedge clk);
        acc_n = 0;
        start = 1'b1; op = code; pc_i = pc; target_i = tgt; fp_i = fp; sp_i = sp;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after start", {31'd0, busy}, 32'd1);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R7 done seen", {31'd0, done}, 32'd1);
        chk("R7 not busy at done", {31'd0, busy}, 32'd0);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk("R7 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        chk("R1 fp", fp_o, 32'd0);
        chk("R1 sp", sp_o, 32'd0);
        chk("R1 pc", pc_o, 32'd0);
    endtask

    task automatic t_call(input logic is_abs, input logic [31:0] pc, input logic [31:0] tgt,
                          input logic [31:0] fp, input logic [31:0] sp, input int l);
        lat = l;
        run_op(is_abs ? 2'b00 : 2'b01, pc, tgt, fp, sp);
        if (is_abs) begin
            chk("R2 first addr", log_addr[0], sp - 32'd8);
            chk("R2 first is write", {31'd0, log_we[0]}, 32'd1);
            chk("R2 return addr", log_wdata[0], pc + 32'd6);
        end else begin
            chk("R3 first addr", log_addr[0], sp - 32'd8);
            chk("R3 return addr", log_wdata[0], pc + 32'd2);
            chk("R3 pc target", pc_o, tgt);
        end
        chk("R4 second addr", log_addr[1], sp - 32'd12);
        chk("R4 second is write", {31'd0, log_we[1]}, 32'd1);
        chk("R4 saved fp", log_wdata[1], fp);
        chk("R4 fp", fp_o, sp - 32'd12);
        chk("R4 sp", sp_o, sp - 32'd12);
        chk("R4 pc", pc_o, tgt);
        chk("R6 access count", acc_n, 32'd2);
        after_done();
    endtask

    task automatic t_ret(input logic [31:0] fp, input logic [31:0] old_fp,
                         input logic [31:0] ra, input int l);
        lat = l;
        mem[fp[7:2]]         = old_fp;
        mem[(fp[7:2] + 6'd1)] = ra;
        run_op(2'b10, 32'h1234, 32'hDEAD, fp, 32'h0000_0010);
        chk("R5 first addr", log_addr[0], fp);
        chk("R5 first is read", {31'd0, log_we[0]}, 32'd0);
        chk("R5 second addr", log_addr[1], fp + 32'd4);
        chk("R5 second is read", {31'd0, log_we[1]}, 32'd0);
        chk("R5 fp", fp_o, old_fp);
        chk("R5 pc", pc_o, ra);
        chk("R5 sp", sp_o, fp + 32'd12);
        chk("R6 access count", acc_n, 32'd2);
        after_done();
    endtask

    // call then return using the call's outputs
    task automatic t_round_trip();
        logic [31:0] f, s;
        lat = 1;
        run_op(2'b00, 32'h0000_0100, 32'h0000_0800, 32'h0000_00C0, 32'h0000_00B0);
        f = fp_o; s = sp_o;
        after_done();
        run_op(2'b10, 32'h0000_0808, 32'h0, f, s);
        chk("R5 round-trip fp", fp_o, 32'h0000_00C0);
        chk("R5 round-trip sp", sp_o, 32'h0000_00B0);
        chk("R5 round-trip pc", pc_o, 32'h0000_0106);
        after_done();
    endtask

    task automatic t_busy_ignore();
        int d0;
        lat = 3;
        d0 = done_n;
        @(negedge clk);
        acc_n = 0;
        start = 1'b1; op = 2'b01; pc_i = 32'h40; target_i = 32'h900; fp_i = 32'h70; sp_i = 32'hA0;
        @(negedge clk);
        op = 2'b10; pc_i = 32'h0; target_i = 32'h0; fp_i = 32'h10; sp_i = 32'h20;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 single done", done_n - d0, 32'd1);
        chk("R8 access count", acc_n, 32'd2);
        chk("R8 fp", fp_o, 32'h94);
        chk("R8 sp", sp_o, 32'h94);
        chk("R8 pc", pc_o, 32'h900);
        chk("R8 return addr", log_wdata[0], 32'h42);
    endtask

    task automatic t_reserved();
        int d0;
        logic [31:0] f, s, p;
        d0 = done_n; f = fp_o; s = sp_o; p = pc_o;
        @(negedge clk);
        acc_n = 0;
        start = 1'b1; op = 2'b11; pc_i = 32'h55; target_i = 32'h66; fp_i = 32'h77; sp_i = 32'h88;
        @(negedge clk);
        start = 1'b0;
        chk("R9 not busy", {31'd0, busy}, 32'd0);
        chk("R9 no request", {31'd0, mem_req}, 32'd0);
        repeat (8) @(negedge clk);
        chk("R9 no access", acc_n, 32'd0);
        chk("R9 no done", done_n - d0, 32'd0);
        chk("R9 fp kept", fp_o, f);
        chk("R9 sp kept", sp_o, s);
        chk("R9 pc kept", pc_o, p);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_call(1'b1, 32'h0000_1000, 32'h0000_2000, 32'h0000_00E0, 32'h0000_00F0, 0);
        t_call(1'b0, 32'h0000_3002, 32'h0000_4400, 32'h0000_0050, 32'h0000_0080, 4);
        t_ret(32'h0000_0040, 32'h0000_0090, 32'h0000_5006, 0);
        t_ret(32'h0000_0020, 32'h0000_0060, 32'h0000_7002, 5);
        t_round_trip();
        t_busy_ignore();
        t_reserved();
        summary();
    end

    initial begin
        #(CYC * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule